// File: doc/BRIEF.md
# Two-Dimensional 8x8 Inverse Integer Transform

This block turns one 8x8 block of signed 16-bit transform coefficients into 64 signed 16-bit residuals. Coefficients enter one per cycle, row by row, through a valid/ready port. Once all 64 have arrived, the block runs an 8-point inverse transform down each column and writes each result back in place. The transposition between the two passes is therefore only a change of addressing. It then runs the same 8-point transform along each row and streams the results out, one per cycle and in row-major order.

Each 8-point transform splits its inputs into two halves. The even half feeds inputs 0, 2, 4 and 6 through a 4-point butterfly built from the weights 64, 83 and 36. The odd half combines inputs 1, 3, 5 and 7 with the weights 89, 75, 50 and 18. The sum of the two halves gives output k, and their difference gives output 7-k. The first pass rounds by 64, shifts by 7 and saturates to 16 bits. The second pass rounds and shifts by an amount set by the static sample bit depth, then saturates.

Top module: `idct8x8_2d`

## Requirements
- R1: While collecting, in_ready is high. A coefficient is taken on each clock edge where in_valid and in_ready are both high, and cycles with in_valid low are skipped. The n-th accepted value (n from 0) is coefficient row n/8, column n%8. No output beat appears after the first coefficient of a block has been accepted.
- R2: After the 64th coefficient is accepted, in_ready is low from the next cycle until the block's last output beat.
- R3: The 8-point transform of s0..s7 is defined as follows. Even part: e0 = 64s0+83s2+64s4+36s6, e1 = 64s0+36s2-64s4-83s6, e2 = 64s0-36s2-64s4+83s6, e3 = 64s0-83s2+64s4-36s6. Odd part: o0 = 89s1+75s3+50s5+18s7, o1 = 75s1-18s3-89s5-50s7, o2 = 50s1-89s3+18s5+75s7, o3 = 18s1-50s3+75s5-89s7. For k = 0..3, y[k] = e[k]+o[k] and y[7-k] = e[k]-o[k]. Each rounding constant is added before the shift.
- R4: The column pass computes (y+64)>>7 with an arithmetic shift and saturates the result to [-32768, 32767]. It stores the result at the same row and column.
- R5: The row pass uses the 16-bit column results. It computes (y + 2^(19-BIT_DEPTH)) >> (20-BIT_DEPTH) with an arithmetic shift and saturates the result to [-32768, 32767].
- R6: The 64 residuals leave as 64 consecutive out_valid beats, in row-major order, with no gap.
- R7: out_done is high on the 64th output beat of a block and on no other cycle.
- R8: After reset, in_ready is 1, out_valid is 0 and out_done is 0.
- R9: When the last beat of a block has been sent, the block accepts the next block at once. The next block's results do not depend on the previous block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coefficient valid |
| in_ready | output | 1 | Block is collecting coefficients |
| in_data | input | DW | Signed coefficient |
| out_valid | output | 1 | Residual valid |
| out_data | output | DW | Signed residual |
| out_done | output | 1 | High on the final residual of a block |

## Verification
The bench builds the block with BIT_DEPTH = 12, so the second pass shifts by only 8. At that setting, full-scale inputs drive the row pass into saturation as well as the column pass; with a larger shift the row pass could never saturate. A single nonzero coefficient is placed at each of the 64 positions in turn, which exercises every weight and the mirrored output of both passes. Blocks of constant extremes, a checkerboard and random blocks, some with input gaps, complete the sweep. Each result is compared with a direct matrix product computed in the bench.

// File: rtl/idct8x8_2d.sv
module idct8x8_2d #(
  parameter int BIT_DEPTH = 8,
  parameter int DW        = 16,
  parameter int ACC_W     = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data,
  output logic                 out_done
);
  localparam int N     = 8;
  localparam int NN    = N * N;
  localparam int LW    = $clog2(N);
  localparam int IW    = $clog2(NN);
  localparam int SH1   = 7;
  localparam int SH2   = 20 - BIT_DEPTH;
  localparam int RND1  = 1 << (SH1 - 1);
  localparam int RND2  = 1 << (SH2 - 1);
  localparam int MAXV  = (1 << (DW - 1)) - 1;
  localparam int MINV  = -(1 << (DW - 1));

  typedef enum logic [1:0] {S_LOAD, S_COL, S_OUT} state_t;

  function automatic logic [DW-1:0] clip(input logic signed [ACC_W-1:0] v, input int sh);
    logic signed [ACC_W-1:0] t;
    t = v >>> sh;
    if (t > MAXV) t = MAXV;
    else if (t < MINV) t = MINV;
    return t[DW-1:0];
  endfunction

  function automatic logic [N-1:0][DW-1:0] pass8(input logic [N-1:0][DW-1:0] s,
                                                 input int sh, input int rnd);
    logic signed [ACC_W-1:0] x [N];
    logic signed [ACC_W-1:0] e [4];
    logic signed [ACC_W-1:0] o [4];
    logic signed [ACC_W-1:0] ea, eb, oa, ob;
    logic [N-1:0][DW-1:0] y;
    for (int i = 0; i < N; i++) x[i] = ACC_W'($signed(s[i]));
    ea = 64 * x[0] + 64 * x[4] + rnd;
    eb = 64 * x[0] - 64 * x[4] + rnd;
    oa = 83 * x[2] + 36 * x[6];
    ob = 36 * x[2] - 83 * x[6];
    e[0] = ea + oa;
    e[1] = eb + ob;
    e[2] = eb - ob;
    e[3] = ea - oa;
    o[0] = 89 * x[1] + 75 * x[3] + 50 * x[5] + 18 * x[7];
    o[1] = 75 * x[1] - 18 * x[3] - 89 * x[5] - 50 * x[7];
    o[2] = 50 * x[1] - 89 * x[3] + 18 * x[5] + 75 * x[7];
    o[3] = 18 * x[1] - 50 * x[3] + 75 * x[5] - 89 * x[7];
    for (int k = 0; k < 4; k++) begin
      y[k]     = clip(e[k] + o[k], sh);
      y[N-1-k] = clip(e[k] - o[k], sh);
    end
    return y;
  endfunction

  state_t         state;
  logic [IW-1:0]  cnt;
  logic [DW-1:0]  mem [NN];
  logic [N-1:0][DW-1:0] col_in, col_out, row_in, row_out;

  wire [LW-1:0] lane = cnt[LW-1:0];
  wire [LW-1:0] line = cnt[IW-1:LW];

  assign in_ready = (state == S_LOAD);

  always_comb begin
    for (int k = 0; k < N; k++) begin
      col_in[k] = mem[{LW'(k), lane}];
      row_in[k] = mem[{line, LW'(k)}];
    end
  end

  assign col_out = pass8(col_in, SH1, RND1);
  assign row_out = pass8(row_in, SH2, RND2);

  always_ff @(posedge clk) begin
    if (state == S_LOAD && in_valid) mem[cnt] <= in_data;
    else if (state == S_COL)
      for (int k = 0; k < N; k++) mem[{LW'(k), lane}] <= col_out[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_LOAD;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_done  <= 1'b0;
    end else begin
      out_valid <= (state == S_OUT);
      out_done  <= (state == S_OUT) && (cnt == IW'(NN - 1));
      out_data  <= row_out[lane];
      case (state)
        S_LOAD: if (in_valid) begin
          cnt <= cnt + 1'b1;
          if (cnt == IW'(NN - 1)) state <= S_COL;
        end
        S_COL: begin
          if (cnt == IW'(N - 1)) begin
            cnt   <= '0;
            state <= S_OUT;
          end else cnt <= cnt + 1'b1;
        end
        S_OUT: begin
          cnt <= cnt + 1'b1;
          if (cnt == IW'(NN - 1)) state <= S_LOAD;
        end
        default: state <= S_LOAD;
      endcase
    end
  end
endmodule

// File: rtl/idct8x8_2d_props.sv
module idct8x8_2d_props (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_done
);
  logic [5:0] acc_cnt, beat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_cnt  <= '0;
      beat_cnt <= '0;
    end else begin
      if (in_valid && in_ready) acc_cnt <= acc_cnt + 1'b1;
      if (out_valid) beat_cnt <= beat_cnt + 1'b1;
    end
  end

  assert_no_out_while_loading_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && acc_cnt != 6'd0) |-> !out_valid);

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && acc_cnt == 6'd63) |=> !in_ready);

  assert_gapless_stream_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_done) |=> out_valid);

  assert_done_on_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> (out_valid && beat_cnt == 6'd63));

  assert_last_has_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && beat_cnt == 6'd63) |-> out_done);

  assert_reset_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_valid && !out_done));
endmodule

bind idct8x8_2d idct8x8_2d_props u_props (.*);

// File: tb/test_idct8x8_2d.sv
module test_idct8x8_2d;
  localparam int BD  = 12;
  localparam int SH2 = 20 - BD;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic in_ready, out_valid, out_done;
  logic signed [15:0] out_data;

  int checks = 0;
  int errors = 0;
  int cin [64];
  int tmp [64];
  int expv [64];
  int T [64] = '{
     64,  64,  64,  64,  64,  64,  64,  64,
     89,  75,  50,  18, -18, -50, -75, -89,
     83,  36, -36, -83, -83, -36,  36,  83,
     75, -18, -89, -50,  50,  89,  18, -75,
     64, -64, -64,  64,  64, -64, -64,  64,
     50, -89,  18,  75, -75, -18,  89, -50,
     36, -83,  83, -36, -36,  83, -83,  36,
     18, -50,  75, -89,  89, -75,  50, -18};

  always #2 clk = ~clk;

  idct8x8_2d #(.BIT_DEPTH(BD)) i_idct8x8_2d (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .out_done(out_done));

  function automatic int sat16(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic compute_ref();
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        int acc = 0;
        for (int k = 0; k < 8; k++) acc += T[k*8+r] * cin[k*8+c];
        tmp[r*8+c] = sat16((acc + 64) >>> 7);
      end
    for (int r = 0; r < 8; r++)
      for (int c = 0; c < 8; c++) begin
        int acc = 0;
        for (int k = 0; k < 8; k++) acc += T[k*8+c] * tmp[r*8+k];
        expv[r*8+c] = sat16((acc + (1 << (SH2 - 1))) >>> SH2);
      end
  endtask

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_block(string tag, bit gaps);
    int idx = 0;
    int waitc = 0;
    bit bad = 0;
    compute_ref();
    check("R1 ready before block", int'(in_ready), 1);
    for (int i = 0; i < 64; i++) begin
      if (gaps && (i % 5 == 2)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data = 16'(cin[i]);
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R2 ready low after 64th", int'(in_ready), 0);
    while (!out_valid && waitc < 300) begin
      @(negedge clk);
      waitc++;
      if (in_ready) bad = 1;
    end
    check("R2 ready low until stream", int'(bad), 0);
    if (!out_valid) check("R6 stream start timeout", 0, 1);
    else begin
      for (int i = 0; i < 64; i++) begin
        if (!out_valid) begin
          check("R6 gap in stream", 0, 1);
          break;
        end
        check(tag, int'(out_data), expv[i]);
        check("R7 done flag", int'(out_done), int'(i == 63));
        idx++;
        if (i == 63) check("R9 ready with last beat", int'(in_ready), 1);
        @(negedge clk);
      end
      check("R6 stream ends after 64", int'(out_valid), 0);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 in_ready after reset", int'(in_ready), 1);
    check("R8 out_valid after reset", int'(out_valid), 0);
    check("R8 out_done after reset", int'(out_done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 64; i++) cin[i] = 0;
    run_block("R3 zero block", 0);

    cin[0] = 1000;
    run_block("R3 R4 R5 DC block", 0);

    for (int p = 0; p < 64; p++) begin
      for (int i = 0; i < 64; i++) cin[i] = 0;
      cin[p] = (p % 2 == 1) ? -(200 + 37 * p) : (200 + 37 * p);
      run_block("R3 impulse", p % 7 == 3);
    end

    for (int i = 0; i < 64; i++) cin[i] = 32767;
    run_block("R4 R5 saturate positive", 0);
    for (int i = 0; i < 64; i++) cin[i] = -32768;
    run_block("R4 R5 saturate negative", 1);
    for (int i = 0; i < 64; i++) cin[i] = (((i / 8) + i) % 2 == 0) ? 32767 : -32768;
    run_block("R4 R5 checkerboard", 0);
    for (int i = 0; i < 64; i++) cin[i] = (i % 8 < 4) ? 12000 : -9000;
    run_block("R3 R5 half split", 0);

    for (int b = 0; b < 10; b++) begin
      for (int i = 0; i < 64; i++) begin
        int v = int'($signed(16'($urandom())));
        cin[i] = (b < 6) ? (v / 64) : v;
      end
      run_block("R3 R4 R5 R9 random", b % 2 == 1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule